// File: doc/BRIEF.md
# Eigenbranch Pool Allocator

A receiver serving several users from one fixed pool of combining branches has to decide, once per frame, which users get how many of those branches. This block holds the eigenvalues reported for each user's antenna correlation (NUM_EIG per user, NUM_USERS users). On a start strobe it picks the NUM_MODS largest values from the whole set of NUM_USERS*NUM_EIG candidates. Each user's share of the winners becomes that user's combining order.

Selection runs one winner per clock, strongest first. Module k of the pool is therefore bound to the k-th strongest eigenmode. The block reports this binding as a (user, eigen-index) pair per module. Results are published together when the frame's selection completes. Users that win nothing are flagged so their datapath can be idled. Eigenvalues are written one at a time through a simple load port while the block is not busy.

Top module: `eig_alloc`

## Requirements
- R1: A write (`wr_en_i` high while not busy) stores `wr_val_i` as the eigenvalue of user `wr_user_i`, index `wr_eig_i`. Stored values persist across frames until rewritten.
- R2: A `start_i` seen while `busy_o` is low raises `busy_o` in the next cycle. `busy_o` stays high for exactly NUM_MODS+1 cycles. It then falls in the same cycle that `done_o` pulses high for one cycle. A `start_i` while busy is ignored.
- R3: The NUM_MODS largest of all candidates (unsigned compare) are selected. `order_o[u*OW +: OW]` equals the number of winners belonging to user u, so the orders sum to NUM_MODS.
- R4: Among equal eigenvalues, the lower user index wins first, and within a user the lower eigen-index wins first.
- R5: `map_user_o[k*UW +: UW]` and `map_eig_o[k*EW +: EW]` give the user and eigen-index of the k-th largest winner (k=0 is the largest). Every mapped user has a nonzero order.
- R6: `idle_o[u]` is high exactly when user u's order is 0.
- R7: Writes while `busy_o` is high are discarded and do not affect the current or any later frame.
- R8: After reset, `busy_o` and `done_o` are low, all orders and map fields are 0, and all idle flags are 1. While busy, the outputs keep the previous frame's results and change only in the `done_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Eigenvalue write strobe |
| wr_user_i | input | UW | User index of the write |
| wr_eig_i | input | EW | Eigen-index of the write |
| wr_val_i | input | VAL_W | Eigenvalue (unsigned) |
| start_i | input | 1 | Start of frame allocation |
| busy_o | output | 1 | Selection in progress |
| done_o | output | 1 | One-cycle pulse when results update |
| order_o | output | NUM_USERS*OW | Per-user combining order |
| idle_o | output | NUM_USERS | Per-user zero-order flag |
| map_user_o | output | NUM_MODS*UW | Per-module owning user |
| map_eig_o | output | NUM_MODS*EW | Per-module eigen-index |

## Verification
The selection is tried with several input patterns:
- A mixed split with two winners for one user and one for the other, which shows that the pick is global rather than per user.
- A pattern where one user takes the whole pool, which exercises the zero-order flag.
- All-equal values and a cross-user tie, which separate the two tie-break levels.
- A single rewritten eigenvalue between frames, which shows that results refresh from stored state.
- Writes and a second start issued mid-frame, which must leave both the running frame and the next frame unchanged.

// File: rtl/eig_alloc_pkg.sv
package eig_alloc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PICK = 2'd1,
    PH_PUB  = 2'd2
  } phase_e;
endpackage

// File: rtl/eig_store.sv
module eig_store #(
  parameter int N_CAND = 8,
  parameter int VAL_W  = 16,
  localparam int AW = (N_CAND > 1) ? $clog2(N_CAND) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [VAL_W-1:0]        data_i,
  output logic [N_CAND*VAL_W-1:0] vals_o
);
  logic [VAL_W-1:0] mem_q [N_CAND];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_CAND; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= data_i;
    end
  end

  for (genvar g = 0; g < N_CAND; g++) begin : g_out
    assign vals_o[g*VAL_W +: VAL_W] = mem_q[g];
  end
endmodule

// File: rtl/eig_argmax.sv
module eig_argmax #(
  parameter int N_CAND = 8,
  parameter int VAL_W  = 16,
  localparam int AW = (N_CAND > 1) ? $clog2(N_CAND) : 1
) (
  input  logic [N_CAND*VAL_W-1:0] vals_i,
  input  logic [N_CAND-1:0]       taken_i,
  output logic [AW-1:0]           win_o
);
  logic [VAL_W-1:0] best;
  logic             found;

  // strict compare: first (lowest flat index) keeps ties
  always_comb begin
    best  = '0;
    found = 1'b0;
    win_o = '0;
    for (int i = 0; i < N_CAND; i++) begin
      if (!taken_i[i] && (!found || vals_i[i*VAL_W +: VAL_W] > best)) begin
        best  = vals_i[i*VAL_W +: VAL_W];
        found = 1'b1;
        win_o = AW'(i);
      end
    end
  end
endmodule

// File: rtl/eig_alloc.sv
module eig_alloc
  import eig_alloc_pkg::*;
#(
  parameter int NUM_USERS = 2,
  parameter int NUM_EIG   = 4,
  parameter int NUM_MODS  = 3,
  parameter int VAL_W     = 16,
  localparam int UW = (NUM_USERS > 1) ? $clog2(NUM_USERS) : 1,
  localparam int EW = (NUM_EIG > 1) ? $clog2(NUM_EIG) : 1,
  localparam int OW = $clog2(NUM_EIG + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [UW-1:0]           wr_user_i,
  input  logic [EW-1:0]           wr_eig_i,
  input  logic [VAL_W-1:0]        wr_val_i,
  input  logic                    start_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [NUM_USERS*OW-1:0] order_o,
  output logic [NUM_USERS-1:0]    idle_o,
  output logic [NUM_MODS*UW-1:0]  map_user_o,
  output logic [NUM_MODS*EW-1:0]  map_eig_o
);
  localparam int N_CAND = NUM_USERS * NUM_EIG;
  localparam int AW     = (N_CAND > 1) ? $clog2(N_CAND) : 1;
  localparam int RW     = (NUM_MODS > 1) ? $clog2(NUM_MODS) : 1;

  phase_e              phase_q;
  logic [RW-1:0]       rnd_q;
  logic [N_CAND-1:0]   taken_q;
  logic [OW-1:0]       cnt_w  [NUM_USERS];
  logic [UW-1:0]       mu_w   [NUM_MODS];
  logic [EW-1:0]       me_w   [NUM_MODS];
  logic [OW-1:0]       ord_q  [NUM_USERS];
  logic [UW-1:0]       mu_q   [NUM_MODS];
  logic [EW-1:0]       me_q   [NUM_MODS];
  logic                done_q;

  logic [N_CAND*VAL_W-1:0] vals;
  logic [AW-1:0]           win;
  logic [UW-1:0]           win_user;
  logic [EW-1:0]           win_eig;
  logic                    wr_ok;
  logic [AW-1:0]           wr_addr;

  assign wr_ok   = wr_en_i && (phase_q == PH_IDLE) &&
                   (int'(wr_user_i) < NUM_USERS) && (int'(wr_eig_i) < NUM_EIG);
  assign wr_addr = AW'(int'(wr_user_i) * NUM_EIG + int'(wr_eig_i));

  eig_store #(.N_CAND(N_CAND), .VAL_W(VAL_W)) store_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_ok),
    .addr_i (wr_addr),
    .data_i (wr_val_i),
    .vals_o (vals)
  );

  eig_argmax #(.N_CAND(N_CAND), .VAL_W(VAL_W)) argmax_i (
    .vals_i  (vals),
    .taken_i (taken_q),
    .win_o   (win)
  );

  assign win_user = UW'(int'(win) / NUM_EIG);
  assign win_eig  = EW'(int'(win) % NUM_EIG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      rnd_q   <= '0;
      taken_q <= '0;
      done_q  <= 1'b0;
      for (int u = 0; u < NUM_USERS; u++) begin
        cnt_w[u] <= '0;
        ord_q[u] <= '0;
      end
      for (int m = 0; m < NUM_MODS; m++) begin
        mu_w[m] <= '0;
        me_w[m] <= '0;
        mu_q[m] <= '0;
        me_q[m] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_PICK;
          rnd_q   <= '0;
          taken_q <= '0;
          for (int u = 0; u < NUM_USERS; u++) cnt_w[u] <= '0;
        end
        PH_PICK: begin
          taken_q[win]    <= 1'b1;
          cnt_w[win_user] <= cnt_w[win_user] + OW'(1);
          mu_w[rnd_q]     <= win_user;
          me_w[rnd_q]     <= win_eig;
          if (int'(rnd_q) == NUM_MODS - 1) phase_q <= PH_PUB;
          else rnd_q <= rnd_q + RW'(1);
        end
        PH_PUB: begin
          for (int u = 0; u < NUM_USERS; u++) ord_q[u] <= cnt_w[u];
          for (int m = 0; m < NUM_MODS; m++) begin
            mu_q[m] <= mu_w[m];
            me_q[m] <= me_w[m];
          end
          done_q  <= 1'b1;
          phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o = (phase_q != PH_IDLE);
  assign done_o = done_q;

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
    assign order_o[u*OW +: OW] = ord_q[u];
    assign idle_o[u]           = (ord_q[u] == '0);
  end
  for (genvar m = 0; m < NUM_MODS; m++) begin : g_mod
    assign map_user_o[m*UW +: UW] = mu_q[m];
    assign map_eig_o[m*EW +: EW]  = me_q[m];
  end
endmodule

// File: rtl/eig_alloc_chk.sv
module eig_alloc_chk #(
  parameter int NUM_USERS = 2,
  parameter int NUM_EIG   = 4,
  parameter int NUM_MODS  = 3,
  localparam int UW = (NUM_USERS > 1) ? $clog2(NUM_USERS) : 1,
  localparam int OW = $clog2(NUM_EIG + 1)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic                    busy_o,
  input logic                    done_o,
  input logic [NUM_USERS*OW-1:0] order_o,
  input logic [NUM_MODS*UW-1:0]  map_user_o
);
  int   ord_sum;
  logic map_ok;

  always_comb begin
    ord_sum = 0;
    for (int u = 0; u < NUM_USERS; u++) ord_sum += int'(order_o[u*OW +: OW]);
    map_ok = 1'b1;
    for (int m = 0; m < NUM_MODS; m++) begin
      if (int'(map_user_o[m*UW +: UW]) >= NUM_USERS) map_ok = 1'b0;
      else if (order_o[int'(map_user_o[m*UW +: UW])*OW +: OW] == '0) map_ok = 1'b0;
    end
  end

  assert_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  assert_done_not_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_order_sum_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ord_sum == NUM_MODS));
  assert_map_owner_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> map_ok);
  assert_hold_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(order_o) && $stable(map_user_o)));
endmodule

bind eig_alloc eig_alloc_chk #(
  .NUM_USERS(NUM_USERS), .NUM_EIG(NUM_EIG), .NUM_MODS(NUM_MODS)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .order_o    (order_o),
  .map_user_o (map_user_o)
);

// File: tb/eig_alloc_tb_top.sv
module eig_alloc_tb_top;
  localparam int NU = 2, NE = 4, NM = 3, VW = 16;
  localparam int UW = 1, EW = 2, OW = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0, start_i = 1'b0;
  logic [UW-1:0] wr_user_i = '0;
  logic [EW-1:0] wr_eig_i = '0;
  logic [VW-1:0] wr_val_i = '0;
  logic busy_o, done_o;
  logic [NU*OW-1:0] order_o;
  logic [NU-1:0]    idle_o;
  logic [NM*UW-1:0] map_user_o;
  logic [NM*EW-1:0] map_eig_o;

  int n_tests = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  eig_alloc #(.NUM_USERS(NU), .NUM_EIG(NE), .NUM_MODS(NM), .VAL_W(VW)) dut_i (.*);

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int u, int e, int v);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_user_i = UW'(u); wr_eig_i = EW'(e); wr_val_i = VW'(v);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic load(int u, int a, int b, int c, int d);
    wr(u, 0, a); wr(u, 1, b); wr(u, 2, c); wr(u, 3, d);
  endtask

  // starts a frame, returns busy length; optional mid-frame disturbance
  task automatic run(output int busy_n, input bit disturb);
    int dn = 0;
    busy_n = 0;
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < 50; i++) begin
      if (done_o) begin dn++; break; end
      if (busy_o) busy_n++;
      if (disturb && busy_n == 2) begin
        wr_en_i = 1'b1; wr_user_i = '0; wr_eig_i = '0; wr_val_i = '0; start_i = 1'b1;
      end else begin
        wr_en_i = 1'b0; start_i = 1'b0;
      end
      @(negedge clk_i);
    end
    wr_en_i = 1'b0; start_i = 1'b0;
    chk("R2", "done seen", dn, 1);
    chk("R2", "busy low at done", int'(busy_o), 0);
    @(negedge clk_i);
    chk("R2", "done one cycle", int'(done_o), 0);
  endtask

  task automatic expect_res(string req, int o0, int o1,
                            int u0, int e0, int u1, int e1, int u2, int e2);
    chk(req, "order u0", int'(order_o[0 +: OW]), o0);
    chk(req, "order u1", int'(order_o[OW +: OW]), o1);
    chk("R6", "idle flags", int'(idle_o), (o0 == 0 ? 1 : 0) + (o1 == 0 ? 2 : 0));
    chk("R5", "map0 user", int'(map_user_o[0]), u0);
    chk("R5", "map0 eig", int'(map_eig_o[0 +: EW]), e0);
    chk("R5", "map1 user", int'(map_user_o[1]), u1);
    chk("R5", "map1 eig", int'(map_eig_o[EW +: EW]), e1);
    chk("R5", "map2 user", int'(map_user_o[2]), u2);
    chk("R5", "map2 eig", int'(map_eig_o[2*EW +: EW]), e2);
  endtask

  task automatic t_reset();
    chk("R8", "busy after reset", int'(busy_o), 0);
    chk("R8", "done after reset", int'(done_o), 0);
    chk("R8", "orders after reset", int'(order_o), 0);
    chk("R8", "idle after reset", int'(idle_o), 3);
    chk("R8", "map after reset", int'({map_user_o, map_eig_o}), 0);
  endtask

  task automatic t_mixed();
    int b;
    load(0, 100, 80, 10, 5);
    load(1, 90, 20, 15, 1);
    run(b, 1'b0);
    chk("R2", "busy length", b, NM + 1);
    expect_res("R3", 2, 1, 0, 0, 1, 0, 0, 1);
  endtask

  task automatic t_hold_while_busy();
    int b;
    // new frame with same data: outputs must not move while busy
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R8", "busy raised", int'(busy_o), 1);
    chk("R8", "order held while busy", int'(order_o[0 +: OW]), 2);
    b = 0;
    while (!done_o && b < 20) begin @(negedge clk_i); b++; end
    expect_res("R8", 2, 1, 0, 0, 1, 0, 0, 1);
  endtask

  task automatic t_refresh();
    int b;
    wr(1, 1, 95);   // only one value changes, rest persist
    run(b, 1'b0);
    expect_res("R1", 1, 2, 0, 0, 1, 1, 1, 0);
  endtask

  task automatic t_one_user();
    int b;
    load(0, 10, 9, 8, 7);
    load(1, 200, 150, 120, 1);
    run(b, 1'b0);
    expect_res("R3", 0, 3, 1, 0, 1, 1, 1, 2);
  endtask

  task automatic t_all_equal();
    int b;
    load(0, 50, 50, 50, 50);
    load(1, 50, 50, 50, 50);
    run(b, 1'b0);
    expect_res("R4", 3, 0, 0, 0, 0, 1, 0, 2);
  endtask

  task automatic t_cross_tie();
    int b;
    load(0, 50, 10, 3, 2);
    load(1, 50, 40, 4, 1);
    run(b, 1'b0);
    expect_res("R4", 1, 2, 0, 0, 1, 0, 1, 1);
  endtask

  task automatic t_busy_ignore();
    int b;
    run(b, 1'b1);   // write u0e0=0 and start pulse mid-frame
    chk("R2", "busy length with start while busy", b, NM + 1);
    expect_res("R7", 1, 2, 0, 0, 1, 0, 1, 1);
    run(b, 1'b0);   // discarded write must not show in later frame
    expect_res("R7", 1, 2, 0, 0, 1, 0, 1, 1);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_mixed();
    t_hold_while_busy();
    t_refresh();
    t_one_user();
    t_all_equal();
    t_cross_tie();
    t_busy_ignore();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule